// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the leading bytes of each received Ethernet frame and decides, from the six-byte destination address, whether the frame is wanted. Bytes arrive on a valid/ready stream. A start marker flags the first byte of a frame and an end marker flags its last byte. The block never stalls the stream: `in_ready` is always high, and a byte is taken in every cycle in which `in_valid` is high. Bytes after the sixth, and bytes that arrive outside a frame, are consumed without effect.

An all-ones destination counts as broadcast. A destination whose first byte has bit 0 set is multicast and is resolved through a 64-entry hash table. When the hash-everything mode is on, unicast destinations are also resolved through the hash table. Any other destination is compared against the station address. The result has two parts. A miss flag reports that the address did not match. An accept flag reports that the frame should be kept, which is true on a match and also on any miss in promiscuous mode.

The mode pins, the station address and the hash table are sampled with the first byte of each frame. A new start marker in the middle of a frame abandons the old frame and begins a new one.

Top module: `rx_dest_filter`

## Requirements
- R1: `in_ready` is always 1. A byte with `in_sof`=1 starts a frame, even in the middle of another frame. Bytes with `in_sof`=0 while no frame is open produce no decision.
- R2: For a frame of six or more bytes, `dec_valid` is high for exactly one cycle, namely the cycle right after the sixth byte is taken. Later bytes of that frame produce no further decision.
- R3: If `in_eof`=1 arrives on byte 1 to 5 of a frame, `dec_valid` rises in the next cycle with `dec_miss`=1.
- R4: A destination of six 0xFF bytes gives `dec_miss` = `cfg_bcast_reject`. Broadcast is checked before the hash and unicast paths.
- R5: A non-broadcast destination whose first byte has bit 0 = 1, or any non-broadcast destination when `cfg_hash_all`=1, is checked against the hash table. The hash index is found as follows:
  - Start a 32-bit CRC at all ones.
  - Shift in each address byte in order, least significant bit first. On each bit, the feedback is the CRC's bit 31 XOR the data bit; the CRC shifts left by one, and if the feedback is 1 it is XORed with 0x04C11DB7. There is no final inversion.
  - The index is CRC bits 31:26.
  - Index bit 5 = 1 selects `hash_hi`, otherwise `hash_lo`. Index bits 4:0 select the bit in that word.
  - A selected bit of 0 means miss.
- R6: Any other destination is compared with the station address. Byte 0 must equal `sta_addr_hi[15:8]`, byte 1 must equal `sta_addr_hi[7:0]`, and bytes 2 to 5 must equal `sta_addr_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Any difference means miss.
- R7: `dec_accept` = !`dec_miss` OR promiscuous, where promiscuous is the value of `cfg_promisc` sampled for that frame.
- R8: The mode pins, station address and hash table are sampled on the start byte. Changing them later in the frame does not change that frame's decision.
- R9: After reset, `dec_valid`, `dec_accept` and `dec_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Always 1; the block takes every offered byte |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| cfg_promisc | input | 1 | Accept frames that miss, still flag the miss |
| cfg_hash_all | input | 1 | Send unicast destinations through the hash table too |
| cfg_bcast_reject | input | 1 | Treat broadcast as a miss |
| sta_addr_hi | input | 16 | Station address bytes 0 and 1 |
| sta_addr_lo | input | 32 | Station address bytes 2 to 5 |
| hash_lo | input | 32 | Hash entries 0 to 31 |
| hash_hi | input | 32 | Hash entries 32 to 63 |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is to be kept |
| dec_miss | output | 1 | Destination did not match |

## Verification
The hardest case to reach from the ports is a hash hit on a chosen half of the table. Only a CRC of the full six bytes tells which table bit is read, so random tables almost never show both outcomes for the same address. The bench therefore searches random multicast addresses until it finds one whose index falls in the upper half and one whose index falls in the lower half. It then programs a table with only that bit set, and another with only that bit cleared. To cover the sampling rule, the configuration pins are scrambled after every start byte, and gaps of idle cycles are inserted between bytes.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int DA_BYTES = 6;
  localparam int DA_BITS  = DA_BYTES * 8;

  typedef struct packed {
    logic promisc;
    logic hash_all;
    logic bcast_reject;
  } dfc_mode_t;
endpackage

// File: rtl/dfc_crc_byte.sv
module dfc_crc_byte #(
  parameter int          CRC_W = 32,
  parameter logic [31:0] POLY  = 32'h04C11DB7
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc_out
);
  localparam logic [CRC_W-1:0] POLY_W = POLY[CRC_W-1:0];

  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ data[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY_W;
    end
    crc_out = c;
  end
endmodule

// File: rtl/dfc_hash_pick.sv
module dfc_hash_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] table_bits,
  input  logic [IDX_W-1:0]   index,
  output logic               bit_set
);
  assign bit_set = table_bits[index];
endmodule

// File: rtl/dfc_frame_track.sv
module dfc_frame_track #(
  parameter int NBYTES = 6,
  localparam int CNT_W = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             take,
  output logic             first,
  output logic [CNT_W-1:0] pos,
  output logic             last,
  output logic             short_end
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NBYTES - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(NBYTES);

  logic [CNT_W-1:0] cnt;
  logic             open_q;

  assign first     = in_valid && in_sof;
  assign take      = first || (in_valid && open_q && cnt < FULL);
  assign pos       = first ? '0 : cnt;
  assign last      = take && (pos == LAST_POS || in_eof);
  assign short_end = take && in_eof && pos < LAST_POS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      open_q <= 1'b0;
    end else if (take) begin
      cnt    <= pos + 1'b1;
      open_q <= !last;
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  p_closed_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !open_q);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import dfc_pkg::*;
#(
  parameter int          HASH_ENTRIES = 64,
  parameter int          CRC_W        = 32,
  parameter logic [31:0] CRC_POLY     = 32'h04C11DB7,
  localparam int         HALF         = HASH_ENTRIES / 2,
  localparam int         IDX_W        = $clog2(HASH_ENTRIES),
  localparam int         CNT_W        = $clog2(DA_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_sof,
  input  logic            in_eof,
  input  logic            cfg_promisc,
  input  logic            cfg_hash_all,
  input  logic            cfg_bcast_reject,
  input  logic [15:0]     sta_addr_hi,
  input  logic [31:0]     sta_addr_lo,
  input  logic [HALF-1:0] hash_lo,
  input  logic [HALF-1:0] hash_hi,
  output logic            dec_valid,
  output logic            dec_accept,
  output logic            dec_miss
);
  logic             take, first, last, short_end;
  logic [CNT_W-1:0] pos;

  dfc_frame_track #(.NBYTES(DA_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .take(take), .first(first), .pos(pos),
    .last(last), .short_end(short_end)
  );

  // Frame settings captured with the start byte
  dfc_mode_t               cap_mode, eff_mode;
  logic [DA_BITS-1:0]      cap_sta, eff_sta;
  logic [HASH_ENTRIES-1:0] cap_hash, eff_hash;

  assign eff_mode = first ? dfc_mode_t'({cfg_promisc, cfg_hash_all, cfg_bcast_reject}) : cap_mode;
  assign eff_sta  = first ? {sta_addr_hi, sta_addr_lo} : cap_sta;
  assign eff_hash = first ? {hash_hi, hash_lo} : cap_hash;

  // Running state over the address bytes
  logic [CRC_W-1:0] crc_q, crc_base, crc_nxt;
  logic             uni_q, bc_q, mc_q;
  logic             uni_nxt, bc_nxt, mc_nxt;
  logic [7:0]       sta_byte;

  assign crc_base = first ? '1 : crc_q;

  dfc_crc_byte #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .crc_in(crc_base), .data(in_data), .crc_out(crc_nxt)
  );

  assign sta_byte = eff_sta[(DA_BITS - 1) - 8 * int'(pos) -: 8];
  assign uni_nxt  = (first ? 1'b1 : uni_q) && (in_data == sta_byte);
  assign bc_nxt   = (first ? 1'b1 : bc_q) && (in_data == 8'hFF);
  assign mc_nxt   = first ? in_data[0] : mc_q;

  logic hash_bit;
  dfc_hash_pick #(.ENTRIES(HASH_ENTRIES)) u_hash (
    .table_bits(eff_hash), .index(crc_nxt[CRC_W-1 -: IDX_W]), .bit_set(hash_bit)
  );

  logic miss_now;
  always_comb begin
    if (short_end)                          miss_now = 1'b1;
    else if (bc_nxt)                        miss_now = eff_mode.bcast_reject;
    else if (mc_nxt || eff_mode.hash_all)   miss_now = !hash_bit;
    else                                    miss_now = !uni_nxt;
  end

  assign in_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_mode   <= '0;
      cap_sta    <= '0;
      cap_hash   <= '0;
      crc_q      <= '1;
      uni_q      <= 1'b0;
      bc_q       <= 1'b0;
      mc_q       <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
    end else begin
      dec_valid <= last;
      if (first) begin
        cap_mode <= eff_mode;
        cap_sta  <= eff_sta;
        cap_hash <= eff_hash;
      end
      if (take) begin
        crc_q <= crc_nxt;
        uni_q <= uni_nxt;
        bc_q  <= bc_nxt;
        mc_q  <= mc_nxt;
      end
      if (last) begin
        dec_miss   <= miss_now;
        dec_accept <= !miss_now || eff_mode.promisc;
      end
    end
  end

  p_dec_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));
  p_match_accepts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_miss) |-> dec_accept);
  p_reject_is_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_accept) |-> dec_miss);
  p_promisc_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cap_mode.promisc) |-> dec_accept);
  p_short_is_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    short_end |=> (dec_valid && dec_miss));
endmodule

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0]  in_data = 0;
  logic        cfg_promisc = 0, cfg_hash_all = 0, cfg_bcast_reject = 0;
  logic [15:0] sta_addr_hi = 0;
  logic [31:0] sta_addr_lo = 0, hash_lo = 0, hash_hi = 0;
  logic        in_ready, dec_valid, dec_accept, dec_miss;

  rx_dest_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .cfg_promisc(cfg_promisc), .cfg_hash_all(cfg_hash_all),
    .cfg_bcast_reject(cfg_bcast_reject), .sta_addr_hi(sta_addr_hi),
    .sta_addr_lo(sta_addr_lo), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference hash index (bench model of R5)
  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        logic f = c[31] ^ da[8*k + i];
        c = (c << 1) ^ (f ? 32'h04C11DB7 : 32'h0);
      end
    return c[31:26];
  endfunction

  // da byte k lives at da[8k +: 8]
  function automatic logic ref_miss(input logic [47:0] da, input int len,
      input logic [15:0] hi, input logic [31:0] lo, input logic [63:0] ht,
      input logic bro, input logic hall);
    logic [47:0] st;
    if (len < 6) return 1'b1;
    if (da == '1) return bro;
    if (da[0] || hall) return !ht[ref_idx(da)];
    st = {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
    return da != st;
  endfunction

  int  seen, bad_time;
  bit  got_acc, got_miss, prev_dec;

  task automatic sample();
    if (dec_valid) begin
      seen++;
      if (!prev_dec) bad_time++;
      got_acc  = dec_accept;
      got_miss = dec_miss;
    end
  endtask

  task automatic scramble();
    cfg_promisc = 1'($urandom); cfg_hash_all = 1'($urandom);
    cfg_bcast_reject = 1'($urandom);
    sta_addr_hi = 16'($urandom); sta_addr_lo = $urandom;
    hash_lo = $urandom; hash_hi = $urandom;
  endtask

  // Sends one frame; settings are applied with the start byte, then scrambled (R8)
  task automatic run_frame(input logic [47:0] da, input int len, input string req,
      input logic pr, input logic hall, input logic bro,
      input logic [15:0] hi, input logic [31:0] lo, input logic [63:0] ht,
      input bit gaps);
    logic em;
    em = ref_miss(da, len, hi, lo, ht, bro, hall);
    seen = 0; bad_time = 0; prev_dec = 0;
    for (int k = 0; k < len; k++) begin
      if (gaps) repeat ($urandom_range(0, 2)) begin
        @(negedge clk); sample(); in_valid = 0; prev_dec = 0;
      end
      @(negedge clk); sample();
      in_valid = 1; in_sof = (k == 0); in_eof = (k == len - 1);
      in_data  = (k < 6) ? da[8*k +: 8] : 8'($urandom);
      prev_dec = (k == 5) || (k < 5 && k == len - 1);
      if (k == 0) begin
        cfg_promisc = pr; cfg_hash_all = hall; cfg_bcast_reject = bro;
        sta_addr_hi = hi; sta_addr_lo = lo; {hash_hi, hash_lo} = ht;
      end else if (k == 1) scramble();
    end
    @(negedge clk); sample();
    in_valid = 0; in_sof = 0; in_eof = 0; prev_dec = 0;
    repeat (2) begin @(negedge clk); sample(); end
    chk(seen == 1, "R2", "decision count", seen, 1);
    chk(bad_time == 0, "R2", "decision timing", bad_time, 0);
    chk(got_miss == em, req, "miss", got_miss, em);
    chk(got_acc == (!em || pr), "R7", "accept", got_acc, !em || pr);
  endtask

  initial begin
    int unsigned wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [47:0] da, st;
    logic [63:0] ht;
    logic [15:0] hi;
    logic [31:0] lo;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(dec_valid == 0 && dec_accept == 0 && dec_miss == 0, "R9", "reset outputs",
        {dec_valid, dec_accept, dec_miss}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1", "ready", in_ready, 1);

    hi = 16'h0A1B; lo = 32'h2C3D4E5F;
    st = {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
    ht = {$urandom, $urandom};

    // R6 exact station match and one-byte mismatch
    run_frame(st, 8, "R6", 0, 0, 0, hi, lo, ht, 0);
    run_frame(st ^ 48'h0000_0100_0000, 6, "R6", 0, 0, 0, hi, lo, ht, 1);
    // R4 broadcast both ways, with hash-all on
    run_frame('1, 7, "R4", 0, 1, 0, hi, lo, 64'h0, 0);
    run_frame('1, 7, "R4", 0, 0, 1, hi, lo, '1, 0);
    run_frame('1, 6, "R4", 1, 0, 1, hi, lo, '1, 0);
    // R3 short frames, including one byte
    run_frame(st, 1, "R3", 0, 0, 0, hi, lo, ht, 0);
    run_frame(st, 5, "R3", 1, 0, 0, hi, lo, ht, 1);
    // R7 promiscuous miss
    run_frame(~st & 48'hFFFF_FFFF_FFFE, 6, "R7", 1, 0, 0, hi, lo, ht, 0);

    // R5 hash hit and miss on each half of the table
    for (int half = 0; half < 2; half++) begin
      logic [5:0] ix;
      do begin
        da = {$urandom, $urandom}; da[0] = 1'b1;
        ix = ref_idx(da);
      end while (ix[5] != half[0] || da == '1);
      run_frame(da, 6, "R5", 0, 0, 0, hi, lo, 64'h1 << ix, 0);
      run_frame(da, 6, "R5", 0, 0, 0, hi, lo, ~(64'h1 << ix), 0);
      // R5 hash-all on the station unicast address
      ix = ref_idx(st);
      run_frame(st, 6, "R5", 0, 1, 0, hi, lo, ~(64'h1 << ix), 0);
    end

    // R1 stray bytes outside a frame, then an abandoned frame restarted by a new start
    seen = 0; prev_dec = 0;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk); sample();
      in_valid = 1; in_sof = (k == 4); in_eof = 0; in_data = 8'($urandom);
    end
    run_frame(st, 6, "R1", 0, 0, 0, hi, lo, ht, 1);

    // Random mixture
    for (int n = 0; n < 200; n++) begin
      int pick = $urandom_range(0, 4);
      hi = 16'($urandom); lo = $urandom; ht = {$urandom, $urandom};
      st = {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
      case (pick)
        0: da = '1;
        1: da = st;
        2: da = st ^ (48'h1 << $urandom_range(1, 47));
        3: begin da = {$urandom, $urandom}; da[0] = 1; end
        default: da = {$urandom, $urandom};
      endcase
      run_frame(da, $urandom_range(1, 10), "R8",
                1'($urandom), 1'($urandom), 1'($urandom), hi, lo, ht, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule